// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

The block holds three independent 16-bit down-counters behind an 8-bit processor port. A two-bit address reaches one data port per counter plus one shared control port. A control byte written to the shared port chooses the target counter, how divisor bytes are transferred, the counting mode and whether the counter runs in binary or in four-digit BCD. The divisor then goes to that counter's own data port, one or two bytes at a time.

Each channel has a count-enable tick input (one system-clock-wide pulse per input clock edge), a gate level input and one output. Three output shapes are supported: a level that rises when the count expires, a periodic one-tick low pulse, and a square wave. All logic runs on the single system clock. A bus access is one system-clock cycle with the chip select and a strobe both low.

Top module: `interval_timer`

## Requirements
- R1: Address 0, 1 and 2 reach the data ports of counters 0, 1 and 2; address 3 is the control port. In a control byte, bit 0 picks BCD (1) or binary (0), bits 3:1 the mode code, bits 5:4 the byte access and bits 7:6 the counter. A select value of 3 has no effect on any channel.
- R2: After reset every output is low and a read of any port returns 0x00.
- R3: Access code 01 transfers only the low byte and code 10 only the high byte; the other byte of the divisor becomes zero.
- R4: With access code 11 the first data write fills the low byte and the second the high byte. No new count is used until the second write. A committed divisor is copied into the counter on the next tick, which is not a counting tick.
- R5: A divisor of zero counts as 65,536 in binary and 10,000 in BCD.
- R6: Mode code 0 (and codes 1, 4, 5) waits for terminal count: a control write or a committed divisor drives the output low. The output rises on the N-th counting tick after the load tick and then stays high while the count keeps wrapping.
- R7: Mode code 2 (and 6) is a rate generator: the output is high for N-1 ticks and low for one tick, after which N is reloaded.
- R8: Mode code 3 (and 7) is a square wave with period N ticks, high for (N+1)/2 ticks and low for N/2 ticks, with the count reloaded at each period.
- R9: While a channel's gate is low, its count and output hold; a pending divisor still loads on a tick.
- R10: In BCD each of the four digits steps down from 0 to 9 with a borrow, so 0000 is followed by 9999.
- R11: A read of a counter port returns the live count in the channel's access order: code 01 the low byte, code 10 the high byte, code 11 low then high on successive reads. A control write restarts both the read and the write order at the low byte.
- R12: A control byte with access code 00 changes nothing in the selected channel.
- R13: A control write of mode code 2, 3, 6 or 7 drives that channel's output high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| addr_i | input | 2 | Port address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid while a read is strobed |
| ch_tick_i | input | 3 | Per-channel input clock tick, one system cycle wide |
| ch_gate_i | input | 3 | Per-channel gate, high enables counting |
| ch_out_o | output | 3 | Per-channel timer output |

## Verification
A wrong byte-order flag shows up on the first data write after a control byte as a divisor off by a factor of 256 or never committed, which moves the first output edge away from its expected tick. A bad BCD borrow or reload appears in the read-back count on the tick where a digit crosses zero, and a wrong square-wave half point moves the falling output edge by one tick in the first period. Outputs are compared on every tick against a model of the tick count since load, so a timing fault surfaces within one period of the divisor.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DIGITS = 4;
  localparam int CW     = 4 * DIGITS;
  localparam int BW     = 8;

  typedef enum logic [1:0] {
    ACC_NONE = 2'b00,
    ACC_LO   = 2'b01,
    ACC_HI   = 2'b10,
    ACC_WORD = 2'b11
  } acc_e;

  typedef enum logic [1:0] {
    OP_TERM   = 2'b00,
    OP_RATE   = 2'b01,
    OP_SQUARE = 2'b10
  } op_e;

  function automatic op_e op_of(logic [2:0] code);
    case (code[1:0])
      2'b10:   return OP_RATE;
      2'b11:   return OP_SQUARE;
      default: return OP_TERM;
    endcase
  endfunction

  // Effective divisor span; zero means the largest count.
  function automatic logic [CW:0] cnt_span(logic [CW-1:0] v, logic bcd);
    logic [CW:0] acc;
    logic [CW:0] wt;
    if (v == '0) return bcd ? (CW+1)'(10 ** DIGITS) : (CW+1)'(1) << CW;
    if (!bcd) return {1'b0, v};
    acc = '0;
    wt  = (CW+1)'(1);
    for (int i = 0; i < DIGITS; i++) begin
      acc = acc + (CW+1)'(v[4*i +: 4]) * wt;
      wt  = wt * (CW+1)'(10);
    end
    return acc;
  endfunction

  function automatic logic bcd_ok(logic [CW-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < DIGITS; i++) if (v[4*i +: 4] > 4'd9) ok = 1'b0;
    return ok;
  endfunction
endpackage

// File: rtl/tmr_decr.sv
module tmr_decr #(
  parameter int DIGITS = 4
) (
  input  logic [4*DIGITS-1:0] val_i,
  input  logic                bcd_i,
  output logic [4*DIGITS-1:0] nxt_o
);
  localparam int W = 4 * DIGITS;

  logic [DIGITS-1:0] brw;
  logic [W-1:0]      bcd_nxt;

  assign brw[0] = 1'b1;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    logic [3:0] dig;
    assign dig = val_i[4*g +: 4];
    assign bcd_nxt[4*g +: 4] = brw[g] ? ((dig == 4'd0) ? 4'd9 : dig - 4'd1) : dig;
    if (g < DIGITS - 1) begin : g_brw
      assign brw[g+1] = brw[g] && (dig == 4'd0);
    end
  end

  assign nxt_o = bcd_i ? bcd_nxt : val_i - W'(1);
endmodule

// File: rtl/tmr_bus.sv
module tmr_bus #(
  parameter int NCH = 3,
  parameter int AW  = 2,
  parameter int BW  = 8
) (
  input  logic                   cs_ni,
  input  logic                   rd_ni,
  input  logic                   wr_ni,
  input  logic [AW-1:0]          addr_i,
  input  logic [1:0]             sel_i,
  input  logic [NCH-1:0][BW-1:0] ch_rdata_i,
  output logic [NCH-1:0]         ctrl_we_o,
  output logic [NCH-1:0]         data_we_o,
  output logic [NCH-1:0]         rd_stb_o,
  output logic [BW-1:0]          rdata_o
);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(NCH);

  logic wr_act, rd_act;
  assign wr_act = !cs_ni && !wr_ni;
  assign rd_act = !cs_ni && !rd_ni;

  for (genvar g = 0; g < NCH; g++) begin : g_dec
    assign ctrl_we_o[g] = wr_act && (addr_i == CTRL_ADDR) && (sel_i == 2'(g));
    assign data_we_o[g] = wr_act && (addr_i == AW'(g));
    assign rd_stb_o[g]  = rd_act && (addr_i == AW'(g));
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NCH; i++) if (rd_stb_o[i]) rdata_o = ch_rdata_i[i];
  end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ctrl_we_i,
  input  logic [5:0]    ctl_i,
  input  logic          data_we_i,
  input  logic          rd_stb_i,
  input  logic [BW-1:0] wdata_i,
  input  logic          tick_i,
  input  logic          gate_i,
  output logic [BW-1:0] rdata_o,
  output logic          out_o
);
  acc_e          acc_q, acc_d;
  op_e           op_q, op_d;
  logic          bcd_q, bcd_d;
  logic          wflip_q, wflip_d, rflip_q, rflip_d;
  logic          pend_q, pend_d, armed_q, armed_d, out_q, out_d;
  logic [CW-1:0] cr_q, cr_d, ce_q, ce_d, ce_dec;
  logic [CW:0]   half;
  logic          commit;

  tmr_decr #(.DIGITS(DIGITS)) u_decr (
    .val_i(ce_q),
    .bcd_i(bcd_q),
    .nxt_o(ce_dec)
  );

  assign half = cnt_span(cr_q, bcd_q) >> 1;

  always_comb begin
    acc_d = acc_q;  op_d = op_q;  bcd_d = bcd_q;
    wflip_d = wflip_q;  rflip_d = rflip_q;
    pend_d = pend_q;  armed_d = armed_q;  out_d = out_q;
    cr_d = cr_q;  ce_d = ce_q;  commit = 1'b0;
    if (ctrl_we_i && (ctl_i[5:4] != 2'b00)) begin
      acc_d   = acc_e'(ctl_i[5:4]);
      op_d    = op_of(ctl_i[3:1]);
      bcd_d   = ctl_i[0];
      wflip_d = 1'b0;
      rflip_d = 1'b0;
      pend_d  = 1'b0;
      armed_d = 1'b0;
      out_d   = (op_of(ctl_i[3:1]) != OP_TERM);
    end else begin
      // counting / loading first, so a same-cycle commit wins
      if (tick_i && pend_q) begin
        ce_d    = cr_q;
        pend_d  = 1'b0;
        armed_d = 1'b1;
        case (op_q)
          OP_TERM: out_d = 1'b0;
          OP_RATE: out_d = 1'b1;
          default: out_d = cnt_span(cr_q, bcd_q) > half;
        endcase
      end else if (tick_i && gate_i && armed_q) begin
        case (op_q)
          OP_TERM: begin
            ce_d = ce_dec;
            if (ce_q == CW'(1)) out_d = 1'b1;
          end
          OP_RATE: begin
            if (ce_q == CW'(1)) begin
              ce_d  = cr_q;
              out_d = 1'b1;
            end else begin
              ce_d = ce_dec;
              if (ce_q == CW'(2)) out_d = 1'b0;
            end
          end
          default: begin
            ce_d  = (ce_q == CW'(1)) ? cr_q : ce_dec;
            out_d = cnt_span(ce_d, bcd_q) > half;
          end
        endcase
      end
      if (data_we_i) begin
        case (acc_q)
          ACC_LO: begin
            cr_d   = {{(CW-BW){1'b0}}, wdata_i};
            commit = 1'b1;
          end
          ACC_HI: begin
            cr_d   = {wdata_i, {(CW-BW){1'b0}}};
            commit = 1'b1;
          end
          ACC_WORD: begin
            if (!wflip_q) begin
              cr_d[BW-1:0] = wdata_i;
              wflip_d      = 1'b1;
            end else begin
              cr_d[CW-1:BW] = wdata_i;
              wflip_d       = 1'b0;
              commit        = 1'b1;
            end
          end
          default: ;
        endcase
        if (commit) begin
          pend_d = 1'b1;
          if (op_q == OP_TERM) out_d = 1'b0;
        end
      end
      if (rd_stb_i && (acc_q == ACC_WORD)) rflip_d = !rflip_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= ACC_NONE;  op_q <= OP_TERM;  bcd_q <= 1'b0;
      wflip_q <= 1'b0;  rflip_q <= 1'b0;
      pend_q <= 1'b0;  armed_q <= 1'b0;  out_q <= 1'b0;
      cr_q <= '0;  ce_q <= '0;
    end else begin
      acc_q <= acc_d;  op_q <= op_d;  bcd_q <= bcd_d;
      wflip_q <= wflip_d;  rflip_q <= rflip_d;
      pend_q <= pend_d;  armed_q <= armed_d;  out_q <= out_d;
      cr_q <= cr_d;  ce_q <= ce_d;
    end
  end

  always_comb begin
    case (acc_q)
      ACC_HI:   rdata_o = ce_q[CW-1:BW];
      ACC_WORD: rdata_o = rflip_q ? ce_q[CW-1:BW] : ce_q[BW-1:0];
      default:  rdata_o = ce_q[BW-1:0];
    endcase
  end

  assign out_o = out_q;

  a_r13_ctl_drives_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_we_i && (ctl_i[5:4] != 2'b00) && ctl_i[2] |=> out_q);

  a_r6_term_stays_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == OP_TERM) && out_q && !ctrl_we_i && !data_we_i |=> out_q);

  a_r9_gate_low_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !gate_i && !pend_q && !ctrl_we_i |=> $stable(ce_q) && $stable(out_q));

  a_r4_word_first_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q == ACC_WORD) && data_we_i && !wflip_q && !ctrl_we_i |=> wflip_q);

  a_r7_single_low_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == OP_RATE) && armed_q && !out_q && tick_i && gate_i && !pend_q
      && !ctrl_we_i && !data_we_i |=> out_q);

  a_r10_bcd_digits_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcd_q && armed_q && !pend_q && tick_i && gate_i && bcd_ok(ce_q) && bcd_ok(cr_q)
      && !ctrl_we_i |=> bcd_ok(ce_q));
endmodule

// File: rtl/interval_timer.sv
module interval_timer #(
  parameter int NCH = 3,
  parameter int AW  = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cs_ni,
  input  logic           rd_ni,
  input  logic           wr_ni,
  input  logic [AW-1:0]  addr_i,
  input  logic [7:0]     wdata_i,
  output logic [7:0]     rdata_o,
  input  logic [NCH-1:0] ch_tick_i,
  input  logic [NCH-1:0] ch_gate_i,
  output logic [NCH-1:0] ch_out_o
);
  import tmr_pkg::*;

  logic [NCH-1:0]         ctrl_we, data_we, rd_stb;
  logic [NCH-1:0][BW-1:0] ch_rdata;

  tmr_bus #(.NCH(NCH), .AW(AW), .BW(BW)) u_bus (
    .cs_ni      (cs_ni),
    .rd_ni      (rd_ni),
    .wr_ni      (wr_ni),
    .addr_i     (addr_i),
    .sel_i      (wdata_i[7:6]),
    .ch_rdata_i (ch_rdata),
    .ctrl_we_o  (ctrl_we),
    .data_we_o  (data_we),
    .rd_stb_o   (rd_stb),
    .rdata_o    (rdata_o)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    tmr_channel u_ch (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ctrl_we_i (ctrl_we[g]),
      .ctl_i     (wdata_i[5:0]),
      .data_we_i (data_we[g]),
      .rd_stb_i  (rd_stb[g]),
      .wdata_i   (wdata_i),
      .tick_i    (ch_tick_i[g]),
      .gate_i    (ch_gate_i[g]),
      .rdata_o   (ch_rdata[g]),
      .out_o     (ch_out_o[g])
    );
  end
endmodule

// File: tb/sim_interval_timer.sv
`timescale 1ns/1ps
module sim_interval_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [2:0] tick = '0;
  logic [2:0] gate = 3'b111;
  logic [2:0] outs;

  always #2.5 clk = ~clk;

  interval_timer u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .rd_ni(rd_n), .wr_ni(wr_n),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .ch_tick_i(tick), .ch_gate_i(gate), .ch_out_o(outs)
  );

  int n_chk = 0, n_err = 0;
  // bench model per channel
  int m_op[3], m_n[3], m_t[3], m_acc[3];
  bit m_bcd[3], m_live[3], m_pend[3];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int modulus(bit bcd);
    return bcd ? 10000 : 65536;
  endfunction

  function automatic logic [15:0] enc(int v, bit bcd);
    int r;
    r = ((v % modulus(bcd)) + modulus(bcd)) % modulus(bcd);
    if (!bcd) return 16'(r);
    return {4'(r / 1000), 4'((r / 100) % 10), 4'((r / 10) % 10), 4'(r % 10)};
  endfunction

  function automatic int dec_raw(logic [15:0] raw, bit bcd);
    int v;
    if (!bcd) v = int'(raw);
    else v = raw[15:12] * 1000 + raw[11:8] * 100 + raw[7:4] * 10 + raw[3:0];
    return (v == 0) ? modulus(bcd) : v;
  endfunction

  // 0 terminal, 1 rate, 2 square (from the low two mode bits)
  function automatic int op_code(int code);
    if ((code & 3) == 2) return 1;
    if ((code & 3) == 3) return 2;
    return 0;
  endfunction

  function automatic bit exp_out(int ch);
    int ph;
    if (!m_live[ch]) return (m_op[ch] != 0);
    if (m_op[ch] == 0) return (m_t[ch] >= m_n[ch]);
    ph = m_t[ch] % m_n[ch];
    if (m_op[ch] == 1) return (ph != m_n[ch] - 1);
    return (ph < (m_n[ch] + 1) / 2);
  endfunction

  function automatic logic [15:0] exp_cnt(int ch);
    if (m_op[ch] == 0) return enc(m_n[ch] - m_t[ch], m_bcd[ch]);
    return enc(m_n[ch] - (m_t[ch] % m_n[ch]), m_bcd[ch]);
  endfunction

  task automatic bus_wr(input int a, input logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; addr = 2'(a); wdata = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic bus_rd(input int a, output logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = 2'(a);
    #1 d = rdata;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic ctl(input int ch, input int code, input int acc, input bit bcd);
    bus_wr(3, {2'(ch), 2'(acc), 3'(code), bcd});
    if (acc != 0) begin
      m_op[ch] = op_code(code); m_acc[ch] = acc; m_bcd[ch] = bcd;
      m_live[ch] = 0; m_pend[ch] = 0;
    end
  endtask

  task automatic load(input int ch, input int v);
    logic [15:0] raw;
    raw = enc(v, m_bcd[ch]);
    if (m_acc[ch] == 1) begin
      raw[15:8] = '0; bus_wr(ch, raw[7:0]);
    end else if (m_acc[ch] == 2) begin
      raw[7:0] = '0; bus_wr(ch, raw[15:8]);
    end else begin
      bus_wr(ch, raw[7:0]); bus_wr(ch, raw[15:8]);
    end
    m_n[ch] = dec_raw(raw, m_bcd[ch]);
    m_pend[ch] = 1;
  endtask

  task automatic run(input int ch, input int n, input string tag);
    @(negedge clk);
    tick[ch] = 1'b1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (m_pend[ch]) begin
        m_pend[ch] = 0; m_live[ch] = 1; m_t[ch] = 0;
      end else if (m_live[ch] && gate[ch]) m_t[ch]++;
      check(outs[ch] == exp_out(ch), tag, outs[ch], exp_out(ch));
    end
    tick[ch] = 1'b0;
  endtask

  task automatic chk_count(input int ch, input string tag);
    logic [7:0]  lo, hi;
    logic [15:0] e;
    e = exp_cnt(ch);
    if (m_acc[ch] == 1) begin
      bus_rd(ch, lo); check(lo == e[7:0], tag, lo, e[7:0]);
    end else if (m_acc[ch] == 2) begin
      bus_rd(ch, hi); check(hi == e[15:8], tag, hi, e[15:8]);
    end else begin
      bus_rd(ch, lo); bus_rd(ch, hi);
      check({hi, lo} == e, tag, {hi, lo}, e);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [7:0] b;
    void'($urandom(32'd5150));
    for (int i = 0; i < 3; i++) begin
      m_op[i] = 0; m_n[i] = 1; m_t[i] = 0; m_acc[i] = 0;
      m_bcd[i] = 0; m_live[i] = 0; m_pend[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    check(outs == 3'b000, "R2 outputs", outs, 0);
    for (int p = 0; p < 4; p++) begin
      bus_rd(p, b); check(b == 8'h00, "R2 read", b, 0);
    end

    // R13 R7 R3 R11: rate, low byte only, N=5
    ctl(1, 2, 1, 0);
    check(outs[1] == 1'b1, "R13 ctl high", outs[1], 1);
    load(1, 5);
    run(1, 12, "R7 rate N=5");
    chk_count(1, "R11 low-byte read");

    // R9 gate low holds
    gate[1] = 1'b0;
    run(1, 6, "R9 gate low out");
    chk_count(1, "R9 gate low count");
    gate[1] = 1'b1;
    run(1, 4, "R7 resume");

    // R12 latch code and R1 select 3 are ignored
    bus_wr(3, 8'h40);
    bus_wr(3, 8'hD4);
    run(1, 7, "R12 ignored ctl");
    check(outs[0] == 1'b0 && outs[2] == 1'b0, "R1 other channels", outs, 0);

    // R4 R8: word access, odd and even square wave
    ctl(0, 3, 3, 0);
    check(outs[0] == 1'b1, "R13 square ctl", outs[0], 1);
    bus_wr(0, 8'h07);
    run(0, 3, "R4 half-written");
    bus_rd(0, b); check(b == 8'h00, "R4 no load lo", b, 0);
    bus_rd(0, b); check(b == 8'h00, "R4 no load hi", b, 0);
    bus_wr(0, 8'h00);
    m_n[0] = 7; m_pend[0] = 1;
    run(0, 22, "R8 square N=7");
    chk_count(0, "R11 word read");
    ctl(0, 3, 3, 0);
    load(0, 6);
    run(0, 14, "R8 square N=6");

    // R3 high byte only
    ctl(1, 2, 2, 0);
    load(1, 256);
    run(1, 1, "R3 load");
    chk_count(1, "R3 high-byte read");
    run(1, 300, "R3 rate N=256");

    // R6 R10: BCD terminal count, wrap to 9999
    ctl(2, 0, 3, 1);
    check(outs[2] == 1'b0, "R6 ctl low", outs[2], 0);
    load(2, 10);
    run(2, 12, "R6 term BCD N=10");
    chk_count(2, "R10 BCD wrap");

    // R5 R8 R10: BCD zero square
    ctl(2, 7, 3, 1);
    load(2, 0);
    run(2, 10005, "R5 BCD zero square");
    chk_count(2, "R10 BCD count");

    // R5 R7: binary zero rate
    ctl(0, 6, 3, 0);
    load(0, 0);
    run(0, 65538, "R5 binary zero rate");
    chk_count(0, "R5 binary count");

    // random mix over channels, mode codes, access and radix (R1 R12 R6 R7 R8)
    for (int it = 0; it < 10; it++) begin
      int ch, code, acc, v;
      bit bcd;
      ch = int'($urandom % 3);
      code = int'($urandom % 8);
      acc = 1 + int'($urandom % 3);
      bcd = 1'($urandom % 2);
      if (acc == 1) v = bcd ? 2 + int'($urandom % 98) : 2 + int'($urandom % 254);
      else if (acc == 2) v = bcd ? 100 * (1 + int'($urandom % 3)) : 256 * (1 + int'($urandom % 2));
      else v = 2 + int'($urandom % 600);
      ctl(ch, code, acc, bcd);
      check(outs[ch] == exp_out(ch), "R6 R13 random ctl", outs[ch], exp_out(ch));
      load(ch, v);
      run(ch, 2 * m_n[ch] + 5, "R1 random run");
      chk_count(ch, "R11 random count");
    end

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule